// File: doc/BRIEF.md
# Two-Stage Pipeline Hazard Controller

This block decides, every cycle, whether the front stage of a two-stage in-order pipeline may hand its instruction to the back stage. The front stage (F) fetches, decodes, reads registers, runs the ALU and increments the PC. The back stage (M) performs the data memory access and the register write, because memory addresses come from the registered ALU result. The controller owns the F-to-M control register. It compares F's decoded source register numbers against the register-writing instruction held in M. It watches M's branch and jump resolution and drives the stall, flush and PC-hold signals for the front end.

Two policies are available through a mode pin. The dependence-aware policy stalls F only on a real read-after-write match and flushes F only when it fetched from the wrong path. The coarse policy flushes F whenever M holds anything other than the bubble, which costs one cycle per instruction but needs no register comparison. In both policies, every cancelled or held-back slot enters M as a dedicated bubble instruction with all side-effect controls cleared.

Top module: `pipe2_hazard_ctrl`

## Requirements
- R1: While reset is low and after it is released, M holds the bubble: word 0x0000000F, destination 0, and register-write, memory-write, branch and jump controls all 0. stall_f and flush_f are 0 when F reads no register that M writes.
- R2: In dependence-aware mode (coarse_mode = 0), stall_f is 1 exactly when M's register-write enable is 1 and m_dst equals f_src_a or f_src_b. Register 0 matches like any other register.
- R3: When stall_f is 1, pc_hold is 1, and after the next rising edge M holds the bubble instead of F's instruction.
- R4: Every slot inserted in place of an F instruction is the bubble word 0x0000000F (secondary opcode 1111 in bits 3:0, every other bit 0), with register-write, memory-write, branch and jump all 0.
- R5: In coarse mode (coarse_mode = 1), stall_f is always 0 and flush_f is 1 whenever m_word differs from 0x0000000F. In that case pc_hold is 1 unless a redirect is also present, so the flushed fetch is repeated.
- R6: A redirect is a jump in M, or a branch in M with m_br_taken = 1. It sets flush_f, clears pc_hold, and places the bubble in M after the next edge. A branch in M with m_br_taken = 0 causes no flush.
- R7: An instruction in M with register-write enable 0, such as a store, never causes a stall, whatever its destination field holds.
- R8: When a redirect and a dependence stall coincide, flush_f is 1 and stall_f is 0.
- R9: A stall lasts exactly one cycle. In the cycle after stall_f is 1, stall_f is 0 even if F's fields are unchanged.
- R10: When neither stall_f nor flush_f is 1, after the next rising edge M holds F's word, destination and control bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| coarse_mode | input | 1 | 1 selects the coarse flush policy, 0 the dependence-aware policy |
| f_src_a | input | REG_W | First source register read by the F instruction |
| f_src_b | input | REG_W | Second source register read by the F instruction |
| f_wr_en | input | 1 | F instruction writes a register |
| f_dst | input | REG_W | Destination register of the F instruction |
| f_mem_wr | input | 1 | F instruction writes data memory |
| f_branch | input | 1 | F instruction is a conditional branch |
| f_jump | input | 1 | F instruction is an unconditional jump |
| f_word | input | 32 | Raw instruction word in F |
| m_br_taken | input | 1 | Branch condition of the M instruction evaluated true |
| stall_f | output | 1 | Hold the F instruction for one cycle |
| flush_f | output | 1 | Discard the F instruction |
| pc_hold | output | 1 | Keep the PC at its present value |
| m_word | output | 32 | Instruction word in M |
| m_wr_en | output | 1 | M instruction writes a register |
| m_dst | output | REG_W | Destination register of the M instruction |
| m_mem_wr | output | 1 | M instruction writes data memory |
| m_branch | output | 1 | M instruction is a conditional branch |
| m_jump | output | 1 | M instruction is an unconditional jump |

## Verification
stall_f, flush_f and pc_hold are combinational. They are due in the same cycle that the F inputs and the M register present a situation. The M register outputs change one rising edge after the decision that filled them. The bench drives all inputs just after a falling edge and samples the decisions one time unit later, well before the next rising edge. It samples the M contents and the one-cycle stall release after the following falling edge. Each scenario first flushes M to a bubble and then loads the chosen producer into M. The decision check therefore always sees exactly one known instruction in M.

// File: rtl/hzc_pkg.sv
// Package: shared constants and types of the two-stage hazard controller.
// Assumes a 32-bit instruction word whose bubble encoding is the
// register-ALU format with secondary opcode 1111 and all other bits zero.
package hzc_pkg;

    localparam int INSTR_W = 32;

    // Dedicated bubble encoding; no side effect of any kind.
    localparam logic [INSTR_W-1:0] BUBBLE_WORD = 32'h0000_000F;

    // Hazard resolution policy selected at the block's mode pin.
    typedef enum logic {
        POL_SMART  = 1'b0,
        POL_COARSE = 1'b1
    } hz_policy_e;

endpackage

// File: rtl/hzc_detect.sv
// Module: hazard decision logic.
// Compares every F source register against M's destination and turns the
// result, M's occupancy and M's redirect into stall/flush/PC-hold requests.
// Assumes the redirect has already been qualified by the branch outcome.
module hzc_detect
    import hzc_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  hz_policy_e              policy,
    input  logic [NSRC*REG_W-1:0]   f_srcs,
    input  logic                    m_wr_en,
    input  logic [REG_W-1:0]        m_dst,
    input  logic                    m_busy,
    input  logic                    m_redirect,
    output logic                    stall_f,
    output logic                    flush_f,
    output logic                    pc_hold
);

    logic [NSRC-1:0] src_hit;
    logic            dep_hit;

    // One comparator per source port; register 0 is not special-cased.
    for (genvar i = 0; i < NSRC; i++) begin : g_src_cmp
        assign src_hit[i] = (f_srcs[i*REG_W +: REG_W] == m_dst);
    end

    // Purpose: a true read-after-write dependence needs a writing producer.
    assign dep_hit = m_wr_en & (|src_hit);

    // Purpose: pick the requests for the selected policy; flush beats stall.
    always_comb begin
        if (policy == POL_COARSE) begin
            flush_f = m_redirect | m_busy;
            stall_f = 1'b0;
            pc_hold = m_busy & ~m_redirect;
        end else begin
            flush_f = m_redirect;
            stall_f = dep_hit & ~m_redirect;
            pc_hold = dep_hit & ~m_redirect;
        end
    end

endmodule

// File: rtl/hzc_mreg.sv
// Module: F-to-M control register.
// Captures F's decoded control each cycle, or the bubble when the F slot is
// killed (stall or flush) or reset is active. Assumes kill is settled
// before the rising edge.
module hzc_mreg
    import hzc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kill,
    input  logic               f_wr_en,
    input  logic [REG_W-1:0]   f_dst,
    input  logic               f_mem_wr,
    input  logic               f_branch,
    input  logic               f_jump,
    input  logic [INSTR_W-1:0] f_word,
    output logic               m_wr_en,
    output logic [REG_W-1:0]   m_dst,
    output logic               m_mem_wr,
    output logic               m_branch,
    output logic               m_jump,
    output logic [INSTR_W-1:0] m_word
);

    // Purpose: advance F into M or insert a side-effect-free bubble.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            m_wr_en  <= 1'b0;
            m_dst    <= '0;
            m_mem_wr <= 1'b0;
            m_branch <= 1'b0;
            m_jump   <= 1'b0;
            m_word   <= BUBBLE_WORD;
        end else begin
            m_wr_en  <= f_wr_en;
            m_dst    <= f_dst;
            m_mem_wr <= f_mem_wr;
            m_branch <= f_branch;
            m_jump   <= f_jump;
            m_word   <= f_word;
        end
    end

    // R4: a killed slot arrives in M as a complete bubble.
    a_r4_bubble_clean: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (m_word == BUBBLE_WORD && !m_wr_en && !m_mem_wr
                  && !m_branch && !m_jump && m_dst == '0));

    // R10: an unkilled slot carries F's word into M.
    a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !kill |=> (m_word == $past(f_word) && m_dst == $past(f_dst)));

endmodule

// File: rtl/pipe2_hazard_ctrl.sv
// Module: top of the two-stage pipeline hazard controller.
// Holds the M-stage control register, qualifies M's branch/jump into a
// redirect, detects occupancy by comparing against the bubble word, and
// drives stall/flush/PC-hold for the front stage. Assumes F's decoded
// fields and m_br_taken are stable before each rising edge.
module pipe2_hazard_ctrl
    import hzc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               coarse_mode,
    input  logic [REG_W-1:0]   f_src_a,
    input  logic [REG_W-1:0]   f_src_b,
    input  logic               f_wr_en,
    input  logic [REG_W-1:0]   f_dst,
    input  logic               f_mem_wr,
    input  logic               f_branch,
    input  logic               f_jump,
    input  logic [31:0]        f_word,
    input  logic               m_br_taken,
    output logic               stall_f,
    output logic               flush_f,
    output logic               pc_hold,
    output logic [31:0]        m_word,
    output logic               m_wr_en,
    output logic [REG_W-1:0]   m_dst,
    output logic               m_mem_wr,
    output logic               m_branch,
    output logic               m_jump
);

    localparam int NSRC = 2;

    logic       m_busy;
    logic       m_redirect;
    logic       kill;
    hz_policy_e policy;

    // Purpose: map the mode pin onto the policy type.
    assign policy     = hz_policy_e'(coarse_mode);
    // Purpose: M is occupied by anything but the bubble encoding.
    assign m_busy     = (m_word != BUBBLE_WORD);
    // Purpose: F was fetched from the wrong path.
    assign m_redirect = m_jump | (m_branch & m_br_taken);
    // Purpose: the F slot does not advance into M this cycle.
    assign kill       = stall_f | flush_f;

    hzc_detect #(
        .REG_W (REG_W),
        .NSRC  (NSRC)
    ) u_detect (
        .policy     (policy),
        .f_srcs     ({f_src_b, f_src_a}),
        .m_wr_en    (m_wr_en),
        .m_dst      (m_dst),
        .m_busy     (m_busy),
        .m_redirect (m_redirect),
        .stall_f    (stall_f),
        .flush_f    (flush_f),
        .pc_hold    (pc_hold)
    );

    hzc_mreg #(
        .REG_W (REG_W)
    ) u_mreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .kill     (kill),
        .f_wr_en  (f_wr_en),
        .f_dst    (f_dst),
        .f_mem_wr (f_mem_wr),
        .f_branch (f_branch),
        .f_jump   (f_jump),
        .f_word   (f_word),
        .m_wr_en  (m_wr_en),
        .m_dst    (m_dst),
        .m_mem_wr (m_mem_wr),
        .m_branch (m_branch),
        .m_jump   (m_jump),
        .m_word   (m_word)
    );

    // R8: stall and flush are never requested together.
    a_r8_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall_f && flush_f));

    // R3: a stalled fetch keeps the PC.
    a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall_f |-> pc_hold);

    // R9: the bubble behind a stall releases it on the next cycle.
    a_r9_progress: assert property (@(posedge clk) disable iff (!rst_n)
        stall_f |=> !stall_f);

    // R6: the wrong-path slot never reaches M as a branch or jump.
    a_r6_wrong_path_gone: assert property (@(posedge clk) disable iff (!rst_n)
        (m_jump || (m_branch && m_br_taken)) |=> (!m_branch && !m_jump && !m_wr_en));

    // R5: the coarse policy never stalls.
    a_r5_coarse_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_mode |-> !stall_f);

endmodule

// File: tb/tb_pipe2_hazard_ctrl.sv
// Bench: exhaustive sweep of the dependence-aware stall over an 8-register
// configuration, then a sweep over every policy/occupancy/redirect/
// dependence combination. Expected values are computed from the rules.
module tb_pipe2_hazard_ctrl;

    localparam int  REG_W    = 3;
    localparam time CLK_PER  = 10;
    localparam logic [31:0] NOPW = 32'h0000_000F;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             coarse_mode = 1'b0;
    logic [REG_W-1:0] f_src_a = '0, f_src_b = '0, f_dst = '0;
    logic             f_wr_en = 1'b0, f_mem_wr = 1'b0, f_branch = 1'b0, f_jump = 1'b0;
    logic [31:0]      f_word = NOPW;
    logic             m_br_taken = 1'b0;
    logic             stall_f, flush_f, pc_hold;
    logic [31:0]      m_word;
    logic             m_wr_en, m_mem_wr, m_branch, m_jump;
    logic [REG_W-1:0] m_dst;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    pipe2_hazard_ctrl #(.REG_W(REG_W)) dut (
        .clk(clk), .rst_n(rst_n), .coarse_mode(coarse_mode),
        .f_src_a(f_src_a), .f_src_b(f_src_b), .f_wr_en(f_wr_en), .f_dst(f_dst),
        .f_mem_wr(f_mem_wr), .f_branch(f_branch), .f_jump(f_jump), .f_word(f_word),
        .m_br_taken(m_br_taken), .stall_f(stall_f), .flush_f(flush_f),
        .pc_hold(pc_hold), .m_word(m_word), .m_wr_en(m_wr_en), .m_dst(m_dst),
        .m_mem_wr(m_mem_wr), .m_branch(m_branch), .m_jump(m_jump)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Put F = bubble for one cycle, then F = producer; after this M holds it.
    task automatic load_m(input logic wr, input logic [REG_W-1:0] dst, input logic mw,
                          input logic br, input logic jp, input logic [31:0] w);
        m_br_taken = 1'b0;
        f_wr_en = 0; f_dst = '0; f_mem_wr = 0; f_branch = 0; f_jump = 0; f_word = NOPW;
        @(negedge clk);
        f_wr_en = wr; f_dst = dst; f_mem_wr = mw; f_branch = br; f_jump = jp; f_word = w;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        #1;
        chk("R1 m_word", m_word, NOPW);
        chk("R1 m_ctrl", {m_wr_en, m_mem_wr, m_branch, m_jump}, 0);
        chk("R1 stall/flush", {stall_f, flush_f}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 after release word", m_word, NOPW);
        chk("R1 after release dst", m_dst, 0);

        // Sweep 1: dependence-aware stall, all producers and sources (R2, R3, R7, R9).
        coarse_mode = 1'b0;
        for (int n = 0; n < 2 * 8 * 8 * 8; n++) begin
            logic w;
            logic [REG_W-1:0] d, a, b;
            logic exp_st;
            w = n[9]; d = n[8:6]; a = n[5:3]; b = n[2:0];
            // A non-writing producer is a store (R7).
            load_m(w, d, ~w, 1'b0, 1'b0, 32'h0100_0000 | n);
            f_src_a = a; f_src_b = b;
            f_wr_en = 0; f_dst = '0; f_mem_wr = 0; f_branch = 0; f_jump = 0;
            f_word = 32'h0200_0000 | n;
            exp_st = w && (d == a || d == b);
            #1;
            chk(w ? "R2 stall" : "R7 store no stall", stall_f, exp_st);
            chk("R2 no flush", flush_f, 0);
            chk("R3 pc_hold", pc_hold, exp_st);
            @(negedge clk);
            #1;
            chk(exp_st ? "R3 bubble in M" : "R10 advance", m_word,
                exp_st ? NOPW : (32'h0200_0000 | n));
            chk("R9 stall released", stall_f, 0);
        end

        // Sweep 2: policy x occupancy x redirect x dependence (R4, R5, R6, R8, R10).
        for (int n = 0; n < 128; n++) begin
            logic cm, busy, wr, br, jp, tk, dep, redir, exp_fl, exp_st, exp_hd, kill;
            cm = n[6]; busy = n[5]; wr = n[4]; br = n[3]; jp = n[2]; tk = n[1]; dep = n[0];
            if (!busy && (wr || br || jp)) continue;
            coarse_mode = cm;
            load_m(wr, 3'd3, 1'b0, br, jp, busy ? (32'h0300_0000 | n) : NOPW);
            f_src_a = dep ? 3'd3 : 3'd5; f_src_b = 3'd6;
            f_wr_en = 1; f_dst = 3'd7; f_mem_wr = 1; f_branch = 1; f_jump = 1;
            f_word = 32'h0400_0000 | n;
            m_br_taken = tk;
            redir  = jp || (br && tk);
            exp_fl = redir || (cm && busy);
            exp_st = !cm && !redir && wr && dep;
            exp_hd = exp_st || (cm && busy && !redir);
            kill   = exp_fl || exp_st;
            #1;
            chk(redir ? "R6 redirect flush" : (cm ? "R5 coarse flush" : "R6 no flush"),
                flush_f, exp_fl);
            chk((redir && wr && dep) ? "R8 flush beats stall" : "R5/R2 stall", stall_f, exp_st);
            chk("R5/R6 pc_hold", pc_hold, exp_hd);
            @(negedge clk);
            m_br_taken = 1'b0;
            #1;
            chk(kill ? "R4 bubble word" : "R10 word", m_word, kill ? NOPW : (32'h0400_0000 | n));
            chk(kill ? "R4 bubble ctrl" : "R10 ctrl", {m_wr_en, m_mem_wr, m_branch, m_jump},
                kill ? 32'h0 : 32'hF);
            chk(kill ? "R4 bubble dst" : "R10 dst", m_dst, kill ? 0 : 7);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule